// File: doc/BRIEF.md
# Spare-Bypass Reconfiguration Controller for a Linear Processor Chain

This block sets the reconfiguration switches of a linear chain that needs `NUM_LOG` working processing elements and is built from `NUM_LOG + NUM_SPARE` physical elements. A fault bitmap names the broken physical elements. The block stores that bitmap when a load strobe is given. From the stored copy it works out which physical element serves each logical position. Healthy elements are taken in ascending physical order, so any set of up to `NUM_SPARE` faults is routed around by shifting. No fixed spare is tied to one particular element.

Each physical element gets two controls. The bypass control makes the chain link skip the element. The output enable marks the element as an active member of the chain. When more faults are stored than there are spares, a fail flag rises and every element is disabled. The mapping is combinational from the stored bitmap. The stored bitmap, and with it all outputs, therefore changes only on the clock edge where the strobe is sampled high. A registered valid flag shows that at least one bitmap has been loaded since reset.

Top module: `spare_chain_router`

## Requirements
- R1: After reset, `mapValid`, `mapFail`, every bit of `bypassCtl` and every bit of `outEnable` are 0.
- R2: The value on `faultMap` is stored on a rising clock edge at which `loadStb` is 1. All outputs reflect the stored bitmap from that edge on, and `mapValid` is 1 from that edge until the next reset.
- R3: While `loadStb` is 0, changes on `faultMap` have no effect on any output.
- R4: When the stored bitmap is not failed, logical position i maps to the physical index of the (i+1)-th zero bit of the stored bitmap, counting upward from bit 0. The index for position i sits in `logIdx[i*IDX_W +: IDX_W]`, with IDX_W = clog2(NUM_LOG+NUM_SPARE).
- R5: `bypassCtl[p]` is 1 exactly when bit p of the stored bitmap is 1, meaning physical element p is faulty.
- R6: When the stored bitmap is valid and not failed, `outEnable[p]` is 1 exactly for the healthy elements that serve a logical position, which is exactly `NUM_LOG` of them. Faulty elements and any surplus healthy elements above them get 0.
- R7: `mapFail` is 1 when the stored bitmap has more than `NUM_SPARE` ones and `mapValid` is 1. While `mapFail` is 1, every `outEnable` bit is 0 and `logIdx` has no defined meaning.
- R8: A bitmap with exactly `NUM_SPARE` faults, at any positions, is not failed and is fully mapped. A bitmap with no faults maps position i to physical element i.
- R9: When the stored bitmap is valid and not failed, the physical indices rise strictly with the logical position, so chain links only run forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultMap | input | NUM_LOG+NUM_SPARE | Fault bitmap, 1 = physical element faulty |
| loadStb | input | 1 | Store `faultMap` on this clock edge |
| mapValid | output | 1 | A bitmap has been stored since reset |
| mapFail | output | 1 | Stored bitmap has more faults than spares |
| logIdx | output | NUM_LOG*IDX_W | Physical index serving each logical position |
| bypassCtl | output | NUM_LOG+NUM_SPARE | Per-element skip switch setting |
| outEnable | output | NUM_LOG+NUM_SPARE | Per-element active-in-chain enable |

## Verification
The assertions assume that `loadStb` and `faultMap` are free of unknown values after reset. Under that assumption they treat any bitmap as legal, including ones with more faults than spares. The stimulus drives both inputs only at falling clock edges and always to defined values. It also covers both sides of the spare limit, meaning exactly `NUM_SPARE` faults and one fault more. Every element faulty is among the cases, as is a change of `faultMap` made with the strobe held low.

// File: rtl/spare_chain_pkg.sv
package spare_chain_pkg;
  typedef struct packed {
    logic capture;    // store the incoming fault bitmap this edge
    logic markValid;  // the stored bitmap is meaningful
  } ctlStrobe_t;
endpackage

// File: rtl/spare_chain_ctl.sv
module spare_chain_ctl
  import spare_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  output ctlStrobe_t strobe
);
  logic validQ;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else if (loadStb) validQ <= 1'b1;
  end

  always_comb begin
    strobe.capture   = loadStb;
    strobe.markValid = validQ;
  end

  // R2: once a bitmap is loaded the valid flag stays up
  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.markValid |=> strobe.markValid);
  // R2: a strobe always leaves the flag set
  assert_load_sets_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> strobe.markValid);
endmodule

// File: rtl/spare_chain_map.sv
module spare_chain_map
  import spare_chain_pkg::*;
#(
  parameter int NUM_LOG   = 8,
  parameter int NUM_SPARE = 2,
  localparam int PHYS  = NUM_LOG + NUM_SPARE,
  localparam int IDX_W = (PHYS > 1) ? $clog2(PHYS) : 1,
  localparam int CNT_W = $clog2(PHYS + 1)
)(
  input  logic                             clk,
  input  logic                             rstN,
  input  ctlStrobe_t                       strobe,
  input  logic [PHYS-1:0]                  faultMap,
  output logic                             mapFail,
  output logic [NUM_LOG-1:0][IDX_W-1:0]    logIdx,
  output logic [PHYS-1:0]                  bypassCtl,
  output logic [PHYS-1:0]                  outEnable
);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
  localparam logic [CNT_W-1:0] LOG_C   = CNT_W'(NUM_LOG);
  localparam logic [CNT_W-1:0] SPARE_C = CNT_W'(NUM_SPARE);

  logic [PHYS-1:0]             faultQ;
  logic [PHYS-1:0][CNT_W-1:0]  healthyRank;
  logic [CNT_W-1:0]            faultCnt;
  logic                        overLimit;
  logic [PHYS-1:0]             usedMask;

  always_ff @(posedge clk) begin
    if (!rstN) faultQ <= '0;
    else if (strobe.capture) faultQ <= faultMap;
  end

  // Rank of each element among healthy ones below it, and the fault total
  always_comb begin
    logic [CNT_W-1:0] runH;
    logic [CNT_W-1:0] runF;
    runH = '0;
    runF = '0;
    for (int p = 0; p < PHYS; p++) begin
      healthyRank[p] = runH;
      if (faultQ[p]) runF = runF + ONE_C;
      else           runH = runH + ONE_C;
    end
    faultCnt = runF;
  end

  assign overLimit = faultCnt > SPARE_C;

  always_comb begin
    for (int p = 0; p < PHYS; p++)
      usedMask[p] = !faultQ[p] && (healthyRank[p] < LOG_C);
  end

  // Logical position i takes the healthy element whose rank equals i
  always_comb begin
    for (int i = 0; i < NUM_LOG; i++) begin
      logIdx[i] = '0;
      for (int p = 0; p < PHYS; p++)
        if (usedMask[p] && healthyRank[p] == CNT_W'(i))
          logIdx[i] = IDX_W'(p);
    end
  end

  assign bypassCtl = faultQ;
  assign mapFail   = strobe.markValid && overLimit;
  assign outEnable = (strobe.markValid && !overLimit) ? usedMask : '0;

  // R3: the stored bitmap moves only on a strobe
  assert_hold_without_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(bypassCtl));
  // R6: a skipped element is never enabled
  assert_bypass_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bypassCtl & outEnable) == '0);
  // R6: a good map enables exactly the logical count
  assert_enable_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.markValid && !mapFail) |-> ($countones(outEnable) == NUM_LOG));
  // R7: a failed map drives no element
  assert_fail_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    mapFail |-> (outEnable == '0));

  for (genvar g = 0; g + 1 < NUM_LOG; g++) begin : gOrder
    // R9: positions are served in rising physical order
    assert_rising_idx_R9: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.markValid && !mapFail) |-> (logIdx[g+1] > logIdx[g]));
  end
endmodule

// File: rtl/spare_chain_router.sv
module spare_chain_router
  import spare_chain_pkg::*;
#(
  parameter int NUM_LOG   = 8,
  parameter int NUM_SPARE = 2,
  localparam int PHYS  = NUM_LOG + NUM_SPARE,
  localparam int IDX_W = (PHYS > 1) ? $clog2(PHYS) : 1
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PHYS-1:0]          faultMap,
  input  logic                     loadStb,
  output logic                     mapValid,
  output logic                     mapFail,
  output logic [NUM_LOG*IDX_W-1:0] logIdx,
  output logic [PHYS-1:0]          bypassCtl,
  output logic [PHYS-1:0]          outEnable
);
  ctlStrobe_t                      strobe;
  logic [NUM_LOG-1:0][IDX_W-1:0]   idxArr;

  spare_chain_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .loadStb (loadStb),
    .strobe  (strobe)
  );

  spare_chain_map #(.NUM_LOG(NUM_LOG), .NUM_SPARE(NUM_SPARE)) u_map (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .faultMap  (faultMap),
    .mapFail   (mapFail),
    .logIdx    (idxArr),
    .bypassCtl (bypassCtl),
    .outEnable (outEnable)
  );

  assign mapValid = strobe.markValid;
  assign logIdx   = idxArr;
endmodule

// File: tb/sim_spare_chain_router.sv
module sim_spare_chain_router;
  localparam int NL = 8;
  localparam int NS = 2;
  localparam int P  = NL + NS;
  localparam int IW = $clog2(P);

  typedef struct {
    logic          valid;
    logic          fail;
    logic [P-1:0]  byp;
    logic [P-1:0]  oe;
    logic [NL*IW-1:0] idx;
    string         tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [P-1:0] faultMap = '0;
  logic loadStb = 1'b0;
  logic mapValid, mapFail;
  logic [NL*IW-1:0] logIdx;
  logic [P-1:0] bypassCtl, outEnable;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  item_t expQ[$];
  item_t lastExp;
  event sampleEv;

  always #4 clk = ~clk;

  spare_chain_router #(.NUM_LOG(NL), .NUM_SPARE(NS)) u0 (
    .clk(clk), .rstN(rstN), .faultMap(faultMap), .loadStb(loadStb),
    .mapValid(mapValid), .mapFail(mapFail), .logIdx(logIdx),
    .bypassCtl(bypassCtl), .outEnable(outEnable)
  );

  function automatic item_t model(input logic [P-1:0] m, input string tag);
    item_t e;
    int nf = 0;
    int k = 0;
    e.valid = 1'b1; e.byp = m; e.oe = '0; e.idx = '0; e.tag = tag;
    for (int p = 0; p < P; p++) if (m[p]) nf++;
    e.fail = (nf > NS);
    if (!e.fail)
      for (int p = 0; p < P; p++)
        if (!m[p] && k < NL) begin
          e.idx[k*IW +: IW] = IW'(p);
          e.oe[p] = 1'b1;
          k++;
        end
    return e;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadMap(input logic [P-1:0] m, input string tag);
    @(negedge clk);
    faultMap = m;
    loadStb = 1'b1;
    lastExp = model(m, tag);
    expQ.push_back(lastExp);
    @(negedge clk);
    loadStb = 1'b0;
    ->sampleEv;
  endtask

  // R3: change input without strobe, expect previous result
  task automatic wiggleNoLoad(input logic [P-1:0] m);
    @(negedge clk);
    faultMap = m;
    lastExp.tag = "R3 no-strobe";
    expQ.push_back(lastExp);
    @(negedge clk);
    @(negedge clk);
    ->sampleEv;
  endtask

  initial begin : monitor
    forever begin
      item_t e;
      @(sampleEv);
      e = expQ.pop_front();
      check({e.tag, " R2 valid"}, 64'(mapValid), 64'(e.valid));
      check({e.tag, " R7 fail"}, 64'(mapFail), 64'(e.fail));
      check({e.tag, " R5 bypass"}, 64'(bypassCtl), 64'(e.byp));
      check({e.tag, " R6 enable"}, 64'(outEnable), 64'(e.oe));
      if (!e.fail) check({e.tag, " R4 index"}, 64'(logIdx), 64'(e.idx));
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : driver
    logic [NL*IW-1:0] ident;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 64'(mapValid), 64'd0);
    check("R1 fail", 64'(mapFail), 64'd0);
    check("R1 bypass", 64'(bypassCtl), 64'd0);
    check("R1 enable", 64'(outEnable), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after release", 64'(mapValid), 64'd0);

    // R8 no faults: identity mapping
    loadMap('0, "R8 clean");
    ident = '0;
    for (int i = 0; i < NL; i++) ident[i*IW +: IW] = IW'(i);
    check("R8 identity", 64'(logIdx), 64'(ident));

    loadMap(P'(1), "R4 low fault");
    loadMap(P'(1) << 2, "R6 surplus spare");
    loadMap((P'(1) << (P-1)) | P'(1), "R8 both ends");
    loadMap(P'(3) << 3, "R8 adjacent pair");
    loadMap(P'(3) << (P-2), "R8 top spares");
    wiggleNoLoad(P'(7) << 1);
    loadMap(P'(7) << 1, "R7 one too many");
    loadMap('1, "R7 all faulty");
    loadMap(P'(5) << 4, "R2 recovery");
    wiggleNoLoad('1);
    loadMap(P'(1) << 5 | P'(1) << 7, "R9 spread");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule